// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block is the link end of an 8-bit ULPI connection between a USB controller and an external PHY. One clock, supplied by the PHY, times every signal. The block watches the PHY's direction and next inputs to decide who owns the data bus. It places bytes from the controller on the bus, paced by next. It closes each outgoing stream with a one-cycle stop strobe. It can also use the same strobe to end a stream that the PHY is driving. Bytes that the PHY sends are passed back to the controller with a valid flag.

The block also handles port power. A Vbus fault input passes through a synchronizer and sets a sticky flag. The flag cuts the power-enable output until the controller clears it. In host mode, two LED requests are passed to the port indicator outputs.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: `ulpi_dout_en` is high only when `ulpi_dir` is low in the current cycle and was low at the previous clock edge. The cycle in which direction changes is a turnaround cycle with the bus released. From reset onward the link does not drive until it has sampled `ulpi_dir` low.
- R2: When the link owns the bus and has no stream in progress, it drives the idle byte 0x00.
- R3: If `tx_valid` is high while the link owns the bus and is idle, `tx_data` is on `ulpi_dout` from the next cycle. A byte stays on the bus until `ulpi_nxt` is high in a cycle the link owns the bus. `tx_ready` is high in exactly that cycle, and the following byte is shown in the next cycle.
- R4: When a byte flagged with `tx_last` is accepted, `ulpi_stop` and `tx_done` are high together in the next cycle for exactly one cycle. The bus shows 0x00 in that cycle.
- R5: `abort_req` is acted on when the link is idle and `ulpi_dir` has been high for the current and previous cycle. In that case `ulpi_stop` is high in the next cycle for exactly one cycle.
- R6: After an abort, `abort_done` pulses for one cycle. The pulse comes in the cycle after the first cycle in which `ulpi_dir` is seen low. A pending transmit puts its first byte on the bus no earlier than two cycles after the pulse.
- R7: `abort_req` while the PHY does not own the bus has no effect: no stop strobe and no `abort_done`.
- R8: A byte on `ulpi_din` is delivered on `rx_data` with `rx_valid` high one cycle later. This happens when `ulpi_dir` is high in that cycle and the previous one and `ulpi_nxt` is high. Turnaround cycles deliver nothing.
- R9: A high `vbus_fault` is seen within three clock edges through a two-stage synchronizer. It forces `vbus_en` low and sets `fault_flag`.
- R10: `fault_flag` stays set after `vbus_fault` falls, and `vbus_en` stays low. Only `fault_clear` resets the flag, and only when the synchronized fault is low.
- R11: With no fault recorded, `vbus_en` follows `vbus_en_req`.
- R12: With `host_mode` high, `port_led` equals `led_req`. With it low, every `port_led` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ulpi_dir | input | 1 | PHY bus-ownership signal, high when the PHY drives |
| ulpi_nxt | input | 1 | PHY byte pacing signal |
| ulpi_din | input | 8 | Data bus as seen from the pads |
| ulpi_dout | output | 8 | Data the link places on the bus |
| ulpi_dout_en | output | 1 | Output enable for the data pads |
| ulpi_stop | output | 1 | One-cycle stream-end strobe |
| tx_valid | input | 1 | Controller has a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_last | input | 1 | Current byte ends the stream |
| tx_ready | output | 1 | Current byte accepted by the PHY |
| tx_done | output | 1 | Outgoing stream closed |
| abort_req | input | 1 | Request to end a PHY-driven stream |
| abort_done | output | 1 | Abort finished, bus handed back |
| rx_data | output | 8 | Byte received from the PHY |
| rx_valid | output | 1 | rx_data holds a new byte |
| vbus_fault | input | 1 | Asynchronous Vbus fault indication |
| fault_clear | input | 1 | Clears the recorded fault |
| vbus_en_req | input | 1 | Controller's request for port power |
| vbus_en | output | 1 | Port power enable |
| fault_flag | output | 1 | Recorded Vbus fault |
| host_mode | input | 1 | Port operates as host |
| led_req | input | 2 | Requested indicator state |
| port_led | output | 2 | Indicator outputs, high for LED on |

## Verification
The bench goes after the turnaround cycles. A design that drives the pads the moment direction falls would show up with the enable high in the release cycle after an abort or at reset exit. It holds next low for several cycles to catch a design that advances bytes without pacing. It also checks that the stop strobe lands exactly one cycle after the final byte, not on the byte and not two cycles later. An abort with a transmit already waiting confirms that no byte escapes before the hand-back pulse plus one cycle. An abort while the link owns the bus confirms that no stray strobe is sent. For power, the bench drops the fault input and tries to clear the flag while the fault is still present. A flag that is not sticky, or that can be cleared too early, would re-enable Vbus in either case.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XMIT,
      ST_STOP,
      ST_ABORT,
      ST_ABWAIT,
      ST_ABDONE
   } link_state_e;
endpackage

// File: rtl/ulpi_bus_fsm.sv
module ulpi_bus_fsm
   import ulpi_link_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] IDLE_BYTE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir,
   input  logic              nxt,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              stop,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_last,
   output logic              tx_ready,
   output logic              tx_done,
   input  logic              abort_req,
   output logic              abort_done,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);
   link_state_e st_q, st_d;
   logic        dir_q;
   logic        link_owns;
   logic        phy_owns;

   // Direction history; reset assumes the PHY holds the bus.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= 1'b1;
      else        dir_q <= dir;
   end

   assign link_owns = !dir && !dir_q;
   assign phy_owns  = dir && dir_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (phy_owns && abort_req)      st_d = ST_ABORT;
            else if (link_owns && tx_valid) st_d = ST_XMIT;
         end
         ST_XMIT:   if (tx_ready && tx_last) st_d = ST_STOP;
         ST_STOP:   st_d = ST_IDLE;
         ST_ABORT:  st_d = ST_ABWAIT;
         ST_ABWAIT: if (!dir) st_d = ST_ABDONE;
         ST_ABDONE: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign dout_en    = link_owns;
   assign dout       = (st_q == ST_XMIT) ? tx_data : IDLE_BYTE;
   assign tx_ready   = (st_q == ST_XMIT) && link_owns && nxt;
   assign stop       = (st_q == ST_STOP) || (st_q == ST_ABORT);
   assign tx_done    = (st_q == ST_STOP);
   assign abort_done = (st_q == ST_ABDONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= phy_owns && nxt;
         if (phy_owns && nxt) rx_data <= din;
      end
   end
endmodule

// File: rtl/ulpi_fault_mon.sv
module ulpi_fault_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_in,
   input  logic fault_clear,
   input  logic vbus_en_req,
   output logic vbus_en,
   output logic fault_flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   fault_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], fault_in};
   end

   assign fault_seen = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           fault_flag <= 1'b0;
      else if (fault_seen)  fault_flag <= 1'b1;
      else if (fault_clear) fault_flag <= 1'b0;
   end

   assign vbus_en = vbus_en_req && !fault_flag && !fault_seen;
endmodule

// File: rtl/ulpi_port_ind.sv
module ulpi_port_ind #(
   parameter int NUM_LEDS = 2
) (
   input  logic                host_mode,
   input  logic [NUM_LEDS-1:0] led_req,
   output logic [NUM_LEDS-1:0] port_led
);
   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      assign port_led[i] = host_mode & led_req[i];
   end
endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_LEDS    = 2,
   parameter logic [DATA_W-1:0] IDLE_BYTE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ulpi_dir,
   input  logic                ulpi_nxt,
   input  logic [DATA_W-1:0]   ulpi_din,
   output logic [DATA_W-1:0]   ulpi_dout,
   output logic                ulpi_dout_en,
   output logic                ulpi_stop,
   input  logic                tx_valid,
   input  logic [DATA_W-1:0]   tx_data,
   input  logic                tx_last,
   output logic                tx_ready,
   output logic                tx_done,
   input  logic                abort_req,
   output logic                abort_done,
   output logic [DATA_W-1:0]   rx_data,
   output logic                rx_valid,
   input  logic                vbus_fault,
   input  logic                fault_clear,
   input  logic                vbus_en_req,
   output logic                vbus_en,
   output logic                fault_flag,
   input  logic                host_mode,
   input  logic [NUM_LEDS-1:0] led_req,
   output logic [NUM_LEDS-1:0] port_led
);
   if (DATA_W != 8) begin : g_bad_width
      $error("ulpi_link_ctrl: DATA_W must be 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ulpi_link_ctrl: SYNC_STAGES must be at least 2");
   end
   if (NUM_LEDS < 1) begin : g_bad_leds
      $error("ulpi_link_ctrl: NUM_LEDS must be at least 1");
   end

   ulpi_bus_fsm #(.DATA_W(DATA_W), .IDLE_BYTE(IDLE_BYTE)) bus_i (
      .clk(clk), .rst_n(rst_n), .dir(ulpi_dir), .nxt(ulpi_nxt), .din(ulpi_din),
      .dout(ulpi_dout), .dout_en(ulpi_dout_en), .stop(ulpi_stop),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_ready(tx_ready), .tx_done(tx_done), .abort_req(abort_req),
      .abort_done(abort_done), .rx_data(rx_data), .rx_valid(rx_valid)
   );

   ulpi_fault_mon #(.SYNC_STAGES(SYNC_STAGES)) fault_i (
      .clk(clk), .rst_n(rst_n), .fault_in(vbus_fault), .fault_clear(fault_clear),
      .vbus_en_req(vbus_en_req), .vbus_en(vbus_en), .fault_flag(fault_flag)
   );

   ulpi_port_ind #(.NUM_LEDS(NUM_LEDS)) led_i (
      .host_mode(host_mode), .led_req(led_req), .port_led(port_led)
   );
endmodule

// File: rtl/ulpi_link_ctrl_chk.sv
module ulpi_link_ctrl_chk #(
   parameter int NUM_LEDS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ulpi_dir,
   input logic                ulpi_nxt,
   input logic                ulpi_dout_en,
   input logic                ulpi_stop,
   input logic                tx_ready,
   input logic                tx_last,
   input logic                tx_done,
   input logic                abort_done,
   input logic                rx_valid,
   input logic                fault_flag,
   input logic                fault_clear,
   input logic                vbus_en,
   input logic                host_mode,
   input logic [NUM_LEDS-1:0] port_led
);
   assert_turnaround_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ulpi_dir || $past(ulpi_dir)) |-> !ulpi_dout_en);
   assert_ready_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (ulpi_nxt && ulpi_dout_en));
   assert_stop_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && tx_last) |=> (ulpi_stop && tx_done));
   assert_stop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ulpi_stop |=> !ulpi_stop);
   assert_done_with_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> ulpi_stop);
   assert_abort_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_done |=> !abort_done);
   assert_rx_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(ulpi_dir && ulpi_nxt));
   assert_fault_cuts_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> !vbus_en);
   assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !fault_clear) |=> fault_flag);
   assert_led_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !host_mode |-> (port_led == '0));
endmodule

bind ulpi_link_ctrl ulpi_link_ctrl_chk #(.NUM_LEDS(NUM_LEDS)) chk_i (
   .clk(clk), .rst_n(rst_n), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
   .ulpi_dout_en(ulpi_dout_en), .ulpi_stop(ulpi_stop), .tx_ready(tx_ready),
   .tx_last(tx_last), .tx_done(tx_done), .abort_done(abort_done),
   .rx_valid(rx_valid), .fault_flag(fault_flag), .fault_clear(fault_clear),
   .vbus_en(vbus_en), .host_mode(host_mode), .port_led(port_led)
);

// File: tb/ulpi_link_ctrl_tb.sv
module ulpi_link_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ulpi_dir, ulpi_nxt;
   logic [7:0] ulpi_din, ulpi_dout;
   logic       ulpi_dout_en, ulpi_stop;
   logic       tx_valid, tx_last, tx_ready, tx_done;
   logic [7:0] tx_data, rx_data;
   logic       abort_req, abort_done, rx_valid;
   logic       vbus_fault, fault_clear, vbus_en_req, vbus_en, fault_flag;
   logic       host_mode;
   logic [1:0] led_req, port_led;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ulpi_link_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
      .ulpi_din(ulpi_din), .ulpi_dout(ulpi_dout), .ulpi_dout_en(ulpi_dout_en),
      .ulpi_stop(ulpi_stop), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_ready(tx_ready), .tx_done(tx_done),
      .abort_req(abort_req), .abort_done(abort_done), .rx_data(rx_data),
      .rx_valid(rx_valid), .vbus_fault(vbus_fault), .fault_clear(fault_clear),
      .vbus_en_req(vbus_en_req), .vbus_en(vbus_en), .fault_flag(fault_flag),
      .host_mode(host_mode), .led_req(led_req), .port_led(port_led)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      ulpi_dir = 0; ulpi_nxt = 0; ulpi_din = 0;
      tx_valid = 0; tx_data = 0; tx_last = 0; abort_req = 0;
      vbus_fault = 0; fault_clear = 0; vbus_en_req = 0;
      host_mode = 0; led_req = 0;
      repeat (3) step();
      check("R1 reset no drive", ulpi_dout_en, 0);
      check("R4 reset stop low", ulpi_stop, 0);
      check("R8 reset rx_valid", rx_valid, 0);
      check("R9 reset fault_flag", fault_flag, 0);
      rst_n = 1'b1;
      step();
      check("R1 drive after dir low", ulpi_dout_en, 1);
      check("R2 idle byte", ulpi_dout, 8'h00);
   endtask

   task automatic test_transmit();
      tx_valid = 1; tx_data = 8'hA5; tx_last = 0; ulpi_nxt = 0;
      step();
      check("R3 first byte shown", ulpi_dout, 8'hA5);
      check("R3 not ready without nxt", tx_ready, 0);
      step();
      check("R3 byte held while nxt low", ulpi_dout, 8'hA5);
      ulpi_nxt = 1; settle();
      check("R3 ready with nxt", tx_ready, 1);
      step();
      tx_data = 8'h3C; tx_last = 1;
      settle();
      check("R3 next byte shown", ulpi_dout, 8'h3C);
      check("R4 no stop on last byte", ulpi_stop, 0);
      step();
      tx_valid = 0; tx_last = 0; ulpi_nxt = 0;
      settle();
      check("R4 stop after last", ulpi_stop, 1);
      check("R4 tx_done with stop", tx_done, 1);
      check("R4 idle byte in stop cycle", ulpi_dout, 8'h00);
      step();
      check("R4 stop one cycle", ulpi_stop, 0);
      check("R4 tx_done one cycle", tx_done, 0);
   endtask

   task automatic test_ignored_abort();
      abort_req = 1;
      step();
      abort_req = 0;
      check("R7 no stop when link owns", ulpi_stop, 0);
      step();
      check("R7 no stop later", ulpi_stop, 0);
      check("R7 no abort_done", abort_done, 0);
      step();
      check("R7 no abort_done later", abort_done, 0);
   endtask

   task automatic test_receive();
      ulpi_dir = 1; ulpi_nxt = 1; ulpi_din = 8'h55;
      settle();
      check("R1 released on dir rise", ulpi_dout_en, 0);
      step();
      check("R8 turnaround delivers nothing", rx_valid, 0);
      check("R1 turnaround no drive", ulpi_dout_en, 0);
      ulpi_din = 8'h6B;
      step();
      check("R8 rx_valid", rx_valid, 1);
      check("R8 rx_data", rx_data, 8'h6B);
      ulpi_nxt = 0;
      step();
      check("R8 rx_valid drops without nxt", rx_valid, 0);
   endtask

   task automatic test_abort();
      // dir has been high for several cycles here
      abort_req = 1;
      step();
      abort_req = 0;
      tx_valid = 1; tx_data = 8'hC3; tx_last = 1; ulpi_nxt = 0;
      settle();
      check("R5 stop on abort", ulpi_stop, 1);
      step();
      check("R5 abort stop one cycle", ulpi_stop, 0);
      check("R6 no early abort_done", abort_done, 0);
      ulpi_dir = 0; settle();
      check("R1 release cycle no drive", ulpi_dout_en, 0);
      step();
      check("R6 abort_done pulse", abort_done, 1);
      check("R6 no tx byte at abort_done", ulpi_dout, 8'h00);
      step();
      check("R6 abort_done one cycle", abort_done, 0);
      check("R6 no tx byte one after abort_done", ulpi_dout, 8'h00);
      step();
      check("R6 pending byte after gap", ulpi_dout, 8'hC3);
      ulpi_nxt = 1;
      step();
      tx_valid = 0; tx_last = 0; ulpi_nxt = 0;
      settle();
      check("R4 stop closes pending stream", ulpi_stop, 1);
      step();
   endtask

   task automatic test_power();
      vbus_en_req = 1; settle();
      check("R11 vbus follows request", vbus_en, 1);
      vbus_en_req = 0; settle();
      check("R11 vbus off with request low", vbus_en, 0);
      vbus_en_req = 1;
      vbus_fault = 1;
      repeat (3) step();
      check("R9 vbus cut by fault", vbus_en, 0);
      check("R9 fault_flag set", fault_flag, 1);
      vbus_fault = 0;
      repeat (4) step();
      check("R10 flag sticky", fault_flag, 1);
      check("R10 vbus stays off", vbus_en, 0);
      vbus_fault = 1;
      repeat (3) step();
      fault_clear = 1;
      step();
      fault_clear = 0;
      check("R10 clear ignored while fault present", fault_flag, 1);
      vbus_fault = 0;
      repeat (4) step();
      fault_clear = 1;
      step();
      fault_clear = 0;
      check("R10 clear resets flag", fault_flag, 0);
      check("R11 vbus back on", vbus_en, 1);
   endtask

   task automatic test_leds();
      host_mode = 0; led_req = 2'b11; settle();
      check("R12 leds off outside host", port_led, 2'b00);
      host_mode = 1; led_req = 2'b10; settle();
      check("R12 led pattern 10", port_led, 2'b10);
      led_req = 2'b01; settle();
      check("R12 led pattern 01", port_led, 2'b01);
   endtask

   initial begin
      test_reset();
      test_transmit();
      test_ignored_abort();
      test_receive();
      test_abort();
      test_power();
      test_leds();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule